// File: doc/BRIEF.md
# UART automatic baud rate detector

This block watches an asynchronous serial receive line and works out the sender's bit rate from a calibration byte. The serial format is 8 data bits, 1 stop bit and no parity. While calibration runs, the host keeps sending the value 0x00. That byte holds the line low for nine bit times in a row: the start bit plus eight zero data bits. The block counts the clock cycles of that low run and divides the count by nine, rounded to the nearest integer. It keeps the result as the per-bit divisor and uses it for both its receiver and its transmitter.

Once the divisor is known and the line has stayed high for one bit time, the block sends a single 0x00 byte back to the host to say that adjustment is complete. It then waits for the host to reply with 0x55. A correct reply sets the locked output. Any of the following sets the error output instead:

- a rate that matches neither supported speed,
- a stop bit that is too short or low,
- a wrong confirmation byte,
- a receive line stuck low.

Both outputs hold their value until a synchronous reset, which is the only way to start calibration again.

The two supported host speeds are given to the block as nominal cycles-per-bit figures. One figure is for the faster rate (19200 bps) and one for the slower rate (9600 bps). A tolerance in cycles applies to both.

Top module: `autobaud_detect`

## Requirements
- R1: While and after reset, tx_out is 1, locked is 0, error is 0 and divisor is 0.
- R2: A low run of L cycles on rx_in produces divisor = round(L/9). The run is accepted only when that value lies within FAST_DIV±TOL or SLOW_DIV±TOL.
- R3: A low pulse shorter than FAST_DIV/2 cycles is ignored. It raises no error, and a later valid calibration still succeeds.
- R4: A measured bit period outside both acceptance windows sets error, and locked stays 0.
- R5: After the low run, rx_in must stay high for at least divisor cycles. A low before that sets error. A low arriving exactly divisor cycles after the rising edge is accepted.
- R6: After the high time, tx_out sends one 0x00 frame with each bit lasting divisor cycles: a start bit at 0, eight data bits at 0 sent LSB first, and a stop bit at 1.
- R7: After the reply frame, a received byte of 0x55 (LSB first, sampled at mid-bit using divisor) with a high stop bit sets locked.
- R8: A confirmation byte other than 0x55, or one whose stop bit is low, sets error.
- R9: The low-run counter saturates at 2^CNT_W-1. If rx_in stays low beyond that, error is set instead of the counter wrapping.
- R10: locked and error are never 1 at the same time. Each stays set, with divisor unchanged, until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_in | input | 1 | Asynchronous serial receive line |
| tx_out | output | 1 | Serial transmit line, idle high |
| divisor | output | CNT_W | Learned cycles per bit |
| locked | output | 1 | Handshake completed |
| error | output | 1 | Calibration or handshake failed |

## Verification
Two events can land on the same cycle:

- the end of the stop-bit window, which requires divisor high cycles;
- the next falling edge on the receive line.

The bench provokes this by holding the line high for exactly divisor cycles in one run and for divisor-1 cycles in another, pulling it low straight afterwards each time. The first run must go on to transmit the reply and lock. The second must raise error. The bench also sweeps the calibration length across both acceptance windows and past their edges. For every length it computes arithmetically whether the run is accepted and what divisor it should produce.

// File: rtl/autobaud_detect.sv
module autobaud_detect #(
  parameter int CNT_W    = 10,
  parameter int FAST_DIV = 16,
  parameter int SLOW_DIV = 32,
  parameter int TOL      = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_in,
  output logic             tx_out,
  output logic [CNT_W-1:0] divisor,
  output logic             locked,
  output logic             error
);

  localparam logic [CNT_W-1:0] CMAX   = '1;
  localparam logic [CNT_W-1:0] GLITCH = CNT_W'(FAST_DIV / 2);
  localparam logic [CNT_W-1:0] F_LO   = CNT_W'(FAST_DIV - TOL);
  localparam logic [CNT_W-1:0] F_HI   = CNT_W'(FAST_DIV + TOL);
  localparam logic [CNT_W-1:0] S_LO   = CNT_W'(SLOW_DIV - TOL);
  localparam logic [CNT_W-1:0] S_HI   = CNT_W'(SLOW_DIV + TOL);
  localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
  localparam logic [7:0]       REPLY  = 8'h00;
  localparam logic [7:0]       ACK    = 8'h55;

  typedef enum logic [2:0] {IDLE, MEAS, STOP, TX, RXW, RXB, LOCK, FAIL} st_t;

  st_t              st;
  logic             s1, s2;
  logic [CNT_W-1:0] cnt, per, bc;
  logic [3:0]       bi;
  logic [9:0]       tsh;
  logic [7:0]       rsh;

  wire             rxs  = s2;
  wire [CNT_W:0]   rnd  = ({1'b0, cnt} + (CNT_W+1)'(4)) / (CNT_W+1)'(9);
  wire [CNT_W-1:0] mper = rnd[CNT_W-1:0];
  wire             rate_ok = (mper >= F_LO && mper <= F_HI) || (mper >= S_LO && mper <= S_HI);

  assign tx_out  = (st == TX) ? tsh[0] : 1'b1;
  assign divisor = per;
  assign locked  = (st == LOCK);
  assign error   = (st == FAIL);

  always_ff @(posedge clk) begin
    if (rst) begin
      s1  <= 1'b1;
      s2  <= 1'b1;
      st  <= IDLE;
      cnt <= '0;
      per <= '0;
      bc  <= '0;
      bi  <= '0;
      tsh <= '1;
      rsh <= '0;
    end else begin
      s1 <= rx_in;
      s2 <= s1;
      case (st)
        IDLE: if (!rxs) begin
          cnt <= ONE;
          st  <= MEAS;
        end
        MEAS: begin
          if (rxs) begin
            if (cnt < GLITCH) st <= IDLE;
            else if (!rate_ok) st <= FAIL;
            else begin
              per <= mper;
              cnt <= ONE;
              st  <= STOP;
            end
          end else if (cnt == CMAX) st <= FAIL;
          else cnt <= cnt + ONE;
        end
        STOP: begin
          if (!rxs) st <= FAIL;
          else if (cnt + ONE == per) begin
            st  <= TX;
            tsh <= {1'b1, REPLY, 1'b0};
            bc  <= '0;
            bi  <= '0;
          end else cnt <= cnt + ONE;
        end
        TX: begin
          if (bc == per - ONE) begin
            bc  <= '0;
            tsh <= {1'b1, tsh[9:1]};
            if (bi == 4'd9) st <= RXW;
            else bi <= bi + 4'd1;
          end else bc <= bc + ONE;
        end
        RXW: if (!rxs) begin
          bc <= (per >> 1) - ONE;
          bi <= '0;
          st <= RXB;
        end
        RXB: begin
          if (bc != '0) bc <= bc - ONE;
          else begin
            bc <= per - ONE;
            if (bi == 4'd0) begin
              if (rxs) st <= RXW;
              else bi <= 4'd1;
            end else if (bi <= 4'd8) begin
              rsh <= {rxs, rsh[7:1]};
              bi  <= bi + 4'd1;
            end else st <= (rxs && rsh == ACK) ? LOCK : FAIL;
          end
        end
        LOCK: st <= LOCK;
        FAIL: st <= FAIL;
        default: st <= FAIL;
      endcase
    end
  end

  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst) !(locked && error)); // R10
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst) error |=> error); // R10
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst) locked |=> (locked && $stable(divisor))); // R10
  AST_LOCK_RATE: assert property (@(posedge clk) disable iff (rst)
    locked |-> ((divisor >= F_LO && divisor <= F_HI) || (divisor >= S_LO && divisor <= S_HI))); // R2
  AST_SAT_ERR: assert property (@(posedge clk) disable iff (rst) (st == MEAS && !rxs && cnt == CMAX) |=> error); // R9
  AST_SHORT_STOP: assert property (@(posedge clk) disable iff (rst) (st == STOP && !rxs) |=> error); // R5
  AST_TX_QUIET: assert property (@(posedge clk) disable iff (rst) (locked || error) |-> tx_out); // R6

endmodule

// File: tb/autobaud_detect_bench.sv
module autobaud_detect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10, FAST_DIV = 16, SLOW_DIV = 32, TOL = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_in = 1'b1;
  logic tx_out, locked, error;
  logic [CNT_W-1:0] divisor;
  int n_chk = 0, n_fail = 0, wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  autobaud_detect #(.CNT_W(CNT_W), .FAST_DIV(FAST_DIV), .SLOW_DIV(SLOW_DIV), .TOL(TOL)) u_autobaud_detect (
    .clk(clk), .rst(rst), .rx_in(rx_in), .tx_out(tx_out),
    .divisor(divisor), .locked(locked), .error(error));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rx_in = 1'b1; rst = 1'b1; cyc(4);
    rst = 1'b0; cyc(2);
  endtask

  task automatic low_high(input int lo, input int hi);
    rx_in = 1'b0; cyc(lo);
    rx_in = 1'b1; cyc(hi);
  endtask

  task automatic send_byte(input int d, input logic [7:0] b, input bit stopb);
    rx_in = 1'b0; cyc(d);
    for (int i = 0; i < 8; i++) begin rx_in = b[i]; cyc(d); end
    rx_in = stopb; cyc(d);
    rx_in = 1'b1;
  endtask

  task automatic get_reply(input int d, output logic [7:0] b, output bit stp, output bit seen);
    seen = 1'b0; b = 8'hFF; stp = 1'b0;
    for (int k = 0; k < 40 * d && !seen; k++) begin
      if (tx_out == 1'b0) seen = 1'b1; else cyc(1);
    end
    if (seen) begin
      cyc(d / 2);
      seen = (tx_out == 1'b0);
      for (int i = 0; i < 8; i++) begin cyc(d); b[i] = tx_out; end
      cyc(d); stp = tx_out;
      cyc(d);
    end
  endtask

  task automatic check_reply(input int d, input string tag);
    logic [7:0] b; bit stp, seen;
    get_reply(d, b, stp, seen);
    chk(seen, {tag, " R6 reply start"}, seen, 1);
    chk(b == 8'h00, {tag, " R6 reply data"}, b, 0);
    chk(stp == 1'b1, {tag, " R6 reply stop"}, stp, 1);
    chk(divisor == d, {tag, " R2 divisor"}, divisor, d);
  endtask

  task automatic run_rate(input int d);
    bit acc;
    acc = (d >= FAST_DIV - TOL && d <= FAST_DIV + TOL) || (d >= SLOW_DIV - TOL && d <= SLOW_DIV + TOL);
    do_reset();
    low_high(9 * d, d);
    if (acc) begin
      check_reply(d, "sweep");
      send_byte(d, 8'h55, 1'b1);
      cyc(3);
      chk(locked == 1'b1, "R7 lock after 0x55", locked, 1);
      chk(error == 1'b0, "R10 no error when locked", error, 0);
    end else begin
      cyc(4);
      chk(error == 1'b1, "R4 out-of-window rate error", error, 1);
      chk(locked == 1'b0, "R4 not locked", locked, 0);
    end
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(2);
    chk(tx_out == 1'b1, "R1 tx idle in reset", tx_out, 1);
    do_reset();
    chk(tx_out == 1'b1, "R1 tx idle", tx_out, 1);
    chk(locked == 1'b0, "R1 locked clear", locked, 0);
    chk(error == 1'b0, "R1 error clear", error, 0);
    chk(divisor == 0, "R1 divisor clear", divisor, 0);

    for (int d = FAST_DIV - TOL - 2; d <= FAST_DIV + TOL + 2; d++) run_rate(d);
    for (int d = SLOW_DIV - TOL - 2; d <= SLOW_DIV + TOL + 2; d++) run_rate(d);

    // R3: glitch below half the fast bit time
    do_reset();
    low_high(FAST_DIV / 2 - 1, 20);
    chk(error == 1'b0, "R3 glitch ignored", error, 0);
    chk(locked == 1'b0, "R3 glitch no lock", locked, 0);
    low_high(9 * FAST_DIV, FAST_DIV);
    check_reply(FAST_DIV, "glitch");
    send_byte(FAST_DIV, 8'h55, 1'b1); cyc(3);
    chk(locked == 1'b1, "R3 calibration after glitch", locked, 1);

    // R3/R4: pulse at the glitch limit is measured and rejected
    do_reset();
    low_high(FAST_DIV / 2, 20);
    chk(error == 1'b1, "R3 pulse at limit measured", error, 1);

    // R5: high time of divisor-1 then low
    do_reset();
    low_high(9 * FAST_DIV, FAST_DIV - 1);
    rx_in = 1'b0; cyc(3); rx_in = 1'b1; cyc(4);
    chk(error == 1'b1, "R5 short stop error", error, 1);

    // R5: high time of exactly divisor then low is accepted
    do_reset();
    low_high(9 * FAST_DIV, FAST_DIV);
    rx_in = 1'b0; cyc(3); rx_in = 1'b1;
    chk(error == 1'b0, "R5 exact stop accepted", error, 0);
    check_reply(FAST_DIV, "exact-stop");
    send_byte(FAST_DIV, 8'h55, 1'b1); cyc(3);
    chk(locked == 1'b1, "R5 exact stop then lock", locked, 1);

    // R8: wrong confirmation byte
    do_reset();
    low_high(9 * SLOW_DIV, SLOW_DIV);
    check_reply(SLOW_DIV, "bad-byte");
    send_byte(SLOW_DIV, 8'h54, 1'b1); cyc(3);
    chk(error == 1'b1, "R8 wrong byte error", error, 1);
    chk(locked == 1'b0, "R8 wrong byte no lock", locked, 0);

    // R8: confirmation with low stop bit
    do_reset();
    low_high(9 * FAST_DIV, FAST_DIV);
    check_reply(FAST_DIV, "bad-stop");
    send_byte(FAST_DIV, 8'h55, 1'b0); cyc(3);
    chk(error == 1'b1, "R8 framing error", error, 1);
    rx_in = 1'b1; cyc(FAST_DIV);
    chk(error == 1'b1, "R10 error sticky", error, 1);

    // R9: stuck-low line saturates
    do_reset();
    rx_in = 1'b0; cyc(1000);
    chk(error == 1'b0, "R9 below saturation", error, 0);
    cyc(40);
    chk(error == 1'b1, "R9 saturation error", error, 1);
    rx_in = 1'b1; cyc(4);
    chk(error == 1'b1, "R10 error held after release", error, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule